// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Register File

This block is the host-visible register file of a SCSI protocol controller. It holds a status byte, an interrupt-cause byte, a sequence-step byte, a FIFO-flags byte, three configuration bytes, the command byte and a three-byte transfer count. The host reaches all of them through one byte-wide port with separate read and write strobes and a 4-bit address. One interrupt line leaves the block.

Command writes are decoded here. No-op, flush, chip reset, bus reset, message accept, pad and the two selection enable/disable commands update the status, interrupt and sequence registers directly. The three selection commands are not executed. They only produce a one-cycle "command accepted" strobe with a mode code, for the bus engine to act on. The interrupt register is read-destructive: reading it hands back the pending cause and clears the interrupt in the same access.

Register map (4-bit address):
- transfer count low/mid/high at 0/1/2
- command at 3
- status at 4
- interrupt at 5
- sequence step at 6
- FIFO flags at 7
- config 1/2/3 at 8/9/10
- 11 to 15 reserved

Read data is registered and appears the cycle after the read strobe. A cycle with both strobes high performs only the write.

Top module: `scsi_irq_regs`

## Requirements
- R1: The `irq` output equals status bit 7 (the interrupt flag). It rises only in the cycle after a command write that raises an interrupt. Raising it while it is already set changes nothing else.
- R2: A read of address 5 returns the interrupt byte as it was before the read, on `host_rdata` one cycle later. The same access zeroes the interrupt byte, clears status bit 4 (count-zero), clears status bit 7, drops `irq` and loads the sequence step with 4.
- R3: A write to address 0, 1 or 2 clears status bit 4.
- R4: Until address 2 has been written once since the last reset, a read of address 2 returns the `CHIP_ID` parameter. After that write it returns the readable high count byte.
- R5: A command byte with bit 7 set copies the three host-written count bytes into the readable count bytes. A command byte with bit 7 clear leaves the readable count bytes unchanged. Until such a copy, count writes are not visible on reads of addresses 0 and 1.
- R6: Opcode 0x03 (bus reset) sets the interrupt byte to 0x80. It raises the interrupt only when config 1 bit 6 is 0.
- R7: Opcode 0x01 (flush) sets the interrupt byte to 0x08 and zeroes the sequence step and flags, and leaves `irq` unchanged.
- R8: Opcode 0x12 (message accept) sets the interrupt byte to 0x20, zeroes the sequence step and flags, and raises the interrupt.
- R9: Opcode 0x18 (pad) sets status bit 4 and clears every other status bit except bit 7, which it keeps. It also sets the interrupt byte to 0x08 and zeroes the sequence step.
- R10: Opcode 0x44 (enable selection) zeroes the interrupt byte with `irq` unchanged. Opcode 0x45 (disable selection) zeroes the interrupt byte and raises the interrupt.
- R11: Opcodes 0x41, 0x42 and 0x43 pulse `sel_go` for one cycle, with `sel_mode` equal to 1, 2 and 3 respectively, and change no register except the command byte. Any opcode outside the ones listed in R6 to R12 also leaves the interrupt byte untouched.
- R12: Reset, and opcode 0x02 (chip reset), zero every register and forget the high-count write, so R4 applies again. Afterwards config 1 reads 7 and `irq` is low.
- R13: Writes to addresses 4 to 7 and 11 to 15 have no effect. Reads of addresses 11 to 15 return 0.
- R14: Config bytes at 8, 9 and 10 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_rd` |
| irq | output | 1 | Interrupt line, mirrors status bit 7 |
| sel_go | output | 1 | One-cycle strobe for an accepted selection command |
| sel_mode | output | 2 | Selection kind while `sel_go` is high: 1 plain, 2 with attention, 3 with attention and stop |

## Verification
The bench sweeps all 128 opcodes from a known interrupt cause of 0x80. A decoder that mapped an opcode wrongly, or let an unlisted opcode touch the interrupt byte, returns the wrong cause on the next interrupt read. Selection commands would also strobe `sel_go` when they should not. The destructive read is checked by reading the interrupt, sequence and status bytes back to back. A design that cleared the byte before sampling it would return 0, and one that forgot the side effects would leave `irq` high or the step at 0. The chip-id window is tested across a write to the high count byte and again after a chip-reset command. A design that never cleared the written flag would return the count instead of the id. Pad is issued with the interrupt already pending, to catch a design that wipes the interrupt flag. Bus reset is issued with config 1 bit 6 set and clear, to catch an interrupt raised regardless of that bit.

// File: rtl/scsi_regs_pkg.sv
package scsi_regs_pkg;

  // register addresses
  localparam int A_TC0   = 0;
  localparam int A_TC1   = 1;
  localparam int A_TC2   = 2;
  localparam int A_CMD   = 3;
  localparam int A_STAT  = 4;
  localparam int A_INTR  = 5;
  localparam int A_SEQ   = 6;
  localparam int A_FLAGS = 7;
  localparam int A_CFG1  = 8;
  localparam int A_CFG2  = 9;
  localparam int A_CFG3  = 10;

  localparam int TC_BYTES  = 3;
  localparam int CFG_REGS  = 3;

  // status bits
  localparam int ST_TC_BIT  = 4;
  localparam int ST_INT_BIT = 7;

  // interrupt causes
  localparam logic [7:0] IC_FUNC_DONE = 8'h08;
  localparam logic [7:0] IC_DISCON    = 8'h20;
  localparam logic [7:0] IC_BUS_RST   = 8'h80;

  localparam logic [7:0] SEQ_DONE     = 8'h04;
  localparam logic [7:0] CFG1_RESET   = 8'h07;
  localparam int         CFG1_NOREP_BIT = 6;

  // opcodes, low 7 bits of the command byte
  localparam logic [6:0] OP_NOP      = 7'h00;
  localparam logic [6:0] OP_FLUSH    = 7'h01;
  localparam logic [6:0] OP_CHIP_RST = 7'h02;
  localparam logic [6:0] OP_BUS_RST  = 7'h03;
  localparam logic [6:0] OP_MSG_ACC  = 7'h12;
  localparam logic [6:0] OP_PAD      = 7'h18;
  localparam logic [6:0] OP_SEL      = 7'h41;
  localparam logic [6:0] OP_SEL_ATN  = 7'h42;
  localparam logic [6:0] OP_SEL_STOP = 7'h43;
  localparam logic [6:0] OP_EN_SEL   = 7'h44;
  localparam logic [6:0] OP_DIS_SEL  = 7'h45;

  typedef struct packed {
    logic       reload;
    logic       flush;
    logic       chip_rst;
    logic       bus_rst;
    logic       msg_acc;
    logic       pad;
    logic       en_sel;
    logic       dis_sel;
    logic       sel;
    logic [1:0] sel_mode;
  } cmd_act_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_regs_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_act_t   act
);
  logic [6:0] op;
  assign op = cmd[6:0];

  always_comb begin
    act = '0;
    act.reload = cmd[7];
    unique case (op)
      OP_FLUSH:    act.flush    = 1'b1;
      OP_CHIP_RST: act.chip_rst = 1'b1;
      OP_BUS_RST:  act.bus_rst  = 1'b1;
      OP_MSG_ACC:  act.msg_acc  = 1'b1;
      OP_PAD:      act.pad      = 1'b1;
      OP_EN_SEL:   act.en_sel   = 1'b1;
      OP_DIS_SEL:  act.dis_sel  = 1'b1;
      OP_SEL, OP_SEL_ATN, OP_SEL_STOP: begin
        act.sel      = 1'b1;
        act.sel_mode = op[1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scsi_xfer_count.sv
module scsi_xfer_count #(
  parameter int         N_BYTES = 3,
  parameter logic [7:0] CHIP_ID = 8'hA2,
  localparam int        IDX_W   = $clog2(N_BYTES)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wdata,
  input  logic             reload,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);
  logic [7:0] host_q [N_BYTES];
  logic [7:0] live_q [N_BYTES];
  logic       top_written_q;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (clr) begin
        host_q[i] <= '0;
        live_q[i] <= '0;
      end else begin
        if (wr_en && wr_idx == IDX_W'(i)) host_q[i] <= wdata;
        if (reload) live_q[i] <= host_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) top_written_q <= 1'b0;
    else if (wr_en && wr_idx == IDX_W'(N_BYTES - 1)) top_written_q <= 1'b1;
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < N_BYTES; i++)
      if (rd_idx == IDX_W'(i)) rd_byte = live_q[i];
    if (rd_idx == IDX_W'(N_BYTES - 1) && !top_written_q) rd_byte = CHIP_ID;
  end
endmodule

// File: rtl/scsi_irq_regs.sv
module scsi_irq_regs
  import scsi_regs_pkg::*;
#(
  parameter int         ADDR_W  = 4,
  parameter logic [7:0] CHIP_ID = 8'hA2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq,
  output logic              sel_go,
  output logic [1:0]        sel_mode
);
  localparam int TC_IDX_W = $clog2(TC_BYTES);
  localparam logic [ADDR_W-1:0] AD_CMD   = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] AD_INTR  = ADDR_W'(A_INTR);
  localparam logic [ADDR_W-1:0] AD_SEQ   = ADDR_W'(A_SEQ);
  localparam logic [ADDR_W-1:0] AD_FLAGS = ADDR_W'(A_FLAGS);
  localparam logic [ADDR_W-1:0] AD_CFG1  = ADDR_W'(A_CFG1);

  logic [7:0] status_q, intr_q, seq_q, flags_q, cmd_q;
  logic [7:0] cfg_q [CFG_REGS];
  logic [7:0] rdata_q, rd_mux, tc_byte;
  logic       sel_go_q;
  logic [1:0] sel_mode_q;
  cmd_act_t   act;

  logic cmd_wr, tc_sel, tc_wr, cfg_sel, do_chip_rst, clr, intr_rd;
  logic [ADDR_W-1:0] cfg_off;

  assign cmd_wr      = host_wr && host_addr == AD_CMD;
  assign tc_sel      = host_addr < ADDR_W'(TC_BYTES);
  assign tc_wr       = host_wr && tc_sel;
  assign cfg_off     = host_addr - AD_CFG1;
  assign cfg_sel     = host_addr >= AD_CFG1 && cfg_off < ADDR_W'(CFG_REGS);
  assign do_chip_rst = cmd_wr && act.chip_rst;
  assign clr         = rst || do_chip_rst;
  assign intr_rd     = host_rd && !host_wr && host_addr == AD_INTR;

  scsi_cmd_decode u_dec (
    .cmd (host_wdata),
    .act (act)
  );

  scsi_xfer_count #(.N_BYTES(TC_BYTES), .CHIP_ID(CHIP_ID)) u_tc (
    .clk     (clk),
    .clr     (clr),
    .wr_en   (tc_wr),
    .wr_idx  (TC_IDX_W'(host_addr)),
    .wdata   (host_wdata),
    .reload  (cmd_wr && act.reload),
    .rd_idx  (TC_IDX_W'(host_addr)),
    .rd_byte (tc_byte)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      status_q <= '0;
      intr_q   <= '0;
      seq_q    <= '0;
      flags_q  <= '0;
      cmd_q    <= '0;
    end else if (cmd_wr) begin
      cmd_q <= host_wdata;
      if (act.flush) begin
        intr_q  <= IC_FUNC_DONE;
        seq_q   <= '0;
        flags_q <= '0;
      end
      if (act.bus_rst) begin
        intr_q <= IC_BUS_RST;
        if (!cfg_q[0][CFG1_NOREP_BIT]) status_q[ST_INT_BIT] <= 1'b1;
      end
      if (act.msg_acc) begin
        intr_q  <= IC_DISCON;
        seq_q   <= '0;
        flags_q <= '0;
        status_q[ST_INT_BIT] <= 1'b1;
      end
      if (act.pad) begin
        status_q <= '0;
        status_q[ST_TC_BIT]  <= 1'b1;
        status_q[ST_INT_BIT] <= status_q[ST_INT_BIT];
        intr_q   <= IC_FUNC_DONE;
        seq_q    <= '0;
      end
      if (act.en_sel) intr_q <= '0;
      if (act.dis_sel) begin
        intr_q <= '0;
        status_q[ST_INT_BIT] <= 1'b1;
      end
    end else if (tc_wr) begin
      status_q[ST_TC_BIT] <= 1'b0;
    end else if (intr_rd) begin
      intr_q <= '0;
      seq_q  <= SEQ_DONE;
      status_q[ST_TC_BIT]  <= 1'b0;
      status_q[ST_INT_BIT] <= 1'b0;
    end
  end

  for (genvar i = 0; i < CFG_REGS; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (clr) cfg_q[i] <= (i == 0) ? CFG1_RESET : 8'h00;
      else if (host_wr && cfg_sel && cfg_off == ADDR_W'(i)) cfg_q[i] <= host_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (tc_sel) rd_mux = tc_byte;
    else if (cfg_sel) begin
      for (int i = 0; i < CFG_REGS; i++)
        if (cfg_off == ADDR_W'(i)) rd_mux = cfg_q[i];
    end else begin
      case (host_addr)
        AD_CMD:   rd_mux = cmd_q;
        AD_STAT:  rd_mux = status_q;
        AD_INTR:  rd_mux = intr_q;
        AD_SEQ:   rd_mux = seq_q;
        AD_FLAGS: rd_mux = flags_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      sel_go_q   <= 1'b0;
      sel_mode_q <= '0;
    end else begin
      if (host_rd && !host_wr) rdata_q <= rd_mux;
      sel_go_q   <= cmd_wr && act.sel;
      sel_mode_q <= (cmd_wr && act.sel) ? act.sel_mode : 2'd0;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = status_q[ST_INT_BIT];
  assign sel_go     = sel_go_q;
  assign sel_mode   = sel_mode_q;
endmodule

// File: rtl/scsi_irq_regs_chk.sv
module scsi_irq_regs_chk
  import scsi_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic [7:0]        host_rdata,
  input logic              irq,
  input logic              sel_go,
  input logic [7:0]        intr_q,
  input logic [7:0]        status_q
);
  logic intr_read, cmd_write;
  assign intr_read = host_rd && !host_wr && host_addr == ADDR_W'(A_INTR);
  assign cmd_write = host_wr && host_addr == ADDR_W'(A_CMD);

  a_r1_rise_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cmd_write));

  a_r2_read_returns_old: assert property (@(posedge clk) disable iff (rst)
    intr_read |=> host_rdata == $past(intr_q));

  a_r2_read_clears: assert property (@(posedge clk) disable iff (rst)
    intr_read |=> !irq && !status_q[ST_TC_BIT] && intr_q == 8'h00);

  a_r3_count_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr < ADDR_W'(TC_BYTES)) |=> !status_q[ST_TC_BIT]);

  a_r7_flush_keeps_irq: assert property (@(posedge clk) disable iff (rst)
    (cmd_write && host_wdata[6:0] == OP_FLUSH) |=> irq == $past(irq));

  a_r8_msg_acc_raises: assert property (@(posedge clk) disable iff (rst)
    (cmd_write && host_wdata[6:0] == OP_MSG_ACC) |=> irq);

  a_r11_sel_from_cmd: assert property (@(posedge clk) disable iff (rst)
    sel_go |-> $past(cmd_write));

  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> !irq && !sel_go);
endmodule

bind scsi_irq_regs scsi_irq_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .irq        (irq),
  .sel_go     (sel_go),
  .intr_q     (intr_q),
  .status_q   (status_q)
);

// File: tb/tb_scsi_irq_regs.sv
module tb_scsi_irq_regs;
  localparam logic [7:0] ID = 8'hA2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq, sel_go;
  logic [1:0] sel_mode;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  scsi_irq_regs #(.ADDR_W(4), .CHIP_ID(ID)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .sel_go(sel_go), .sel_mode(sel_mode)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [7:0] exp_intr(input logic [6:0] op);
    case (op)
      7'h01, 7'h18: return 8'h08;
      7'h02, 7'h44, 7'h45: return 8'h00;
      7'h12: return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 irq after reset", {7'd0, irq}, 8'h00);
    rd(4'd8, v);  chk("R12 cfg1 reset", v, 8'h07);
    rd(4'd4, v);  chk("R12 status reset", v, 8'h00);
    // R4 chip id window
    rd(4'd2, v);  chk("R4 id before write", v, ID);

    // R13 read-only / reserved writes ignored
    for (int a = 4; a < 16; a++)
      if (a < 8 || a > 10) wr(4'(a), 8'hFF);
    rd(4'd4, v); chk("R13 status untouched", v, 8'h00);
    rd(4'd6, v); chk("R13 seq untouched", v, 8'h00);
    rd(4'd7, v); chk("R13 flags untouched", v, 8'h00);
    for (int a = 11; a < 16; a++) begin
      rd(4'(a), v); chk("R13 reserved reads zero", v, 8'h00);
    end
    rd(4'd5, v); chk("R13 intr untouched", v, 8'h00);
    chk("R13 irq untouched", {7'd0, irq}, 8'h00);

    // R14 config readback
    wr(4'd9, 8'hA5); wr(4'd10, 8'h3C);
    rd(4'd9, v);  chk("R14 cfg2", v, 8'hA5);
    rd(4'd10, v); chk("R14 cfg3", v, 8'h3C);
    rd(4'd8, v);  chk("R14 cfg1 kept", v, 8'h07);

    // R4/R5 transfer count
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h33);
    rd(4'd2, v); chk("R4 after write no id", v, 8'h00);
    rd(4'd0, v); chk("R5 no copy before dma cmd", v, 8'h00);
    wr(4'd3, 8'h80);
    rd(4'd0, v); chk("R5 reload lo", v, 8'h11);
    rd(4'd1, v); chk("R5 reload mid", v, 8'h22);
    rd(4'd2, v); chk("R5 reload hi", v, 8'h33);
    wr(4'd0, 8'h44); wr(4'd3, 8'h00);
    rd(4'd0, v); chk("R5 non-dma keeps count", v, 8'h11);

    // R6 bus reset with reporting enabled
    wr(4'd3, 8'h03);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    rd(4'd5, v); chk("R6 cause", v, 8'h80);
    // R2 side effects of the interrupt read
    chk("R2 irq dropped", {7'd0, irq}, 8'h00);
    rd(4'd6, v); chk("R2 seq step done", v, 8'h04);
    rd(4'd5, v); chk("R2 intr zeroed", v, 8'h00);
    // R6 reporting disabled
    wr(4'd8, 8'h47); wr(4'd3, 8'h03);
    chk("R6 irq suppressed", {7'd0, irq}, 8'h00);
    rd(4'd5, v); chk("R6 cause suppressed", v, 8'h80);

    // R9 pad with irq low, then R3
    wr(4'd3, 8'h18);
    rd(4'd4, v); chk("R9 pad status", v, 8'h10);
    rd(4'd6, v); chk("R9 pad seq", v, 8'h00);
    wr(4'd1, 8'h55);
    rd(4'd4, v); chk("R3 count write clears tc", v, 8'h00);
    // R10 disable selection raises, R1 repeat raise, R9 pad keeps flag
    wr(4'd3, 8'h45);
    chk("R10 dis_sel raises", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h45);
    chk("R1 raise while set", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h18);
    rd(4'd4, v); chk("R9 pad keeps int", v, 8'h90);
    chk("R1 irq follows status", {7'd0, irq}, 8'h01);
    wr(4'd3, 8'h44);
    chk("R10 en_sel irq unchanged", {7'd0, irq}, 8'h01);
    rd(4'd5, v); chk("R10 en_sel zeroes cause", v, 8'h00);
    rd(4'd4, v); chk("R2 status cleared", v, 8'h00);

    // R7 flush then R8 message accept
    wr(4'd3, 8'h01);
    chk("R7 flush no irq", {7'd0, irq}, 8'h00);
    rd(4'd6, v); chk("R7 flush seq", v, 8'h00);
    rd(4'd7, v); chk("R7 flush flags", v, 8'h00);
    rd(4'd5, v); chk("R7 flush cause", v, 8'h08);
    wr(4'd3, 8'h12);
    chk("R8 msg_acc raises", {7'd0, irq}, 8'h01);
    rd(4'd6, v); chk("R8 msg_acc seq", v, 8'h00);
    rd(4'd5, v); chk("R8 msg_acc cause", v, 8'h20);

    // R12 chip reset command
    wr(4'd3, 8'h45);
    wr(4'd2, 8'h77);
    wr(4'd3, 8'h02);
    chk("R12 chip reset drops irq", {7'd0, irq}, 8'h00);
    rd(4'd8, v);  chk("R12 cfg1 after chip reset", v, 8'h07);
    rd(4'd9, v);  chk("R12 cfg2 after chip reset", v, 8'h00);
    rd(4'd2, v);  chk("R12 id window reopened", v, ID);

    // R11 and decoder sweep over every opcode
    for (int op = 0; op < 128; op++) begin
      logic is_sel;
      is_sel = (op >= 8'h41 && op <= 8'h43);
      wr(4'd8, 8'h07);
      wr(4'd3, 8'h03);
      wr(4'd3, 8'(op));
      chk("R11 sel_go", {7'd0, sel_go}, {7'd0, is_sel});
      chk("R11 sel_mode", {6'd0, sel_mode}, is_sel ? 8'(op - 8'h40) : 8'h00);
      rd(4'd5, v);
      chk("R11 opcode sweep cause", v, exp_intr(7'(op)));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule